// File: doc/BRIEF.md
# CPU Interrupt Control Unit

This block keeps the interrupt state of a small 8-bit CPU core and decides how the core answers an interrupt. It holds two interrupt-enable flip-flops. The first gates maskable requests. The second is a shadow copy that survives a non-maskable interrupt and can be restored later. Single-cycle strobes from the instruction decoder update these flip-flops. The block also returns the parity-flag value that the two special register-load instructions (load A from the interrupt-vector register and load A from the refresh register) need.

At each instruction boundary the block looks at a latched rising edge on the non-maskable request and at the level of the maskable request. A non-maskable interrupt produces a restart to address 0066h. The fetched instruction is discarded and no wait states are added. A maskable interrupt first holds the acknowledge cycle for two extra wait states. It then produces one of two responses, depending on the stored interrupt mode:
- In mode 1, and in mode 2, which this block treats as mode 1, it issues a restart to address 0038h.
- In mode 0, it hands over an instruction byte read from the interrupting device's data bus. The block keeps the device bus selected until the next boundary, so the operand bytes of a multi-byte instruction also come from the device.

Top module: `cpu_irq_ctl`

## Requirements
- R1: After reset both enable flip-flops and the parity flag read 0, the interrupt mode reads 0, and no response, wait or device fetch is signalled.
- R2: A disable strobe clears both enable flip-flops one cycle later. An enable strobe sets both of them one cycle later.
- R3: The special-load strobe copies the second enable flip-flop onto `parity_flag` one cycle later and leaves both flip-flops unchanged.
- R4: Accepting a non-maskable interrupt clears the first enable flip-flop and keeps the second. The return-from-non-maskable strobe copies the second flip-flop into the first.
- R5: A rising edge on `nmi_req` is latched until it is serviced. It is accepted at the next `insn_bound` whatever the enable state. In the cycle after that boundary, `resp_valid`, `resp_restart` and `resp_nmi` are 1 and `resp_vector` is 16'h0066, with no wait cycles.
- R6: A maskable request is a level. It is accepted only at an `insn_bound` cycle while `iff1` is 1, and acceptance clears both enable flip-flops.
- R7: When a latched non-maskable edge and a maskable request meet at the same boundary, only the non-maskable interrupt is answered.
- R8: After a maskable acceptance, `ack_wait` is 1 for exactly two cycles. `resp_valid` follows in the third cycle and lasts exactly one cycle.
- R9: In mode 1 (`im_val`=1) and mode 2 (`im_val`=2), the maskable response has `resp_restart`=1, `resp_nmi`=0 and `resp_vector`=16'h0038.
- R10: In mode 0 (`im_val`=0), the maskable response has `resp_restart`=0, and `resp_opcode` is the `ack_data` byte sampled at the clock edge that ends the second wait cycle. `dev_fetch` is 1 from the response cycle until the clock edge that samples the next `insn_bound`.
- R11: `im_wr` stores `im_val` as the mode seen on `im_mode`. Without `im_wr` the mode holds.
- R12: `insn_bound` is ignored while a maskable response is in its wait or response cycles. A pending non-maskable edge waits for the next boundary after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_bound | input | 1 | Instruction boundary; interrupts are sampled here |
| op_di | input | 1 | Disable-interrupts strobe |
| op_ei | input | 1 | Enable-interrupts strobe |
| op_ld_spec | input | 1 | Special register load strobe (vector or refresh register into A) |
| op_retn | input | 1 | Return-from-non-maskable strobe |
| im_wr | input | 1 | Interrupt mode write strobe |
| im_val | input | 2 | Interrupt mode value |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_req | input | 1 | Maskable request, level sensitive |
| ack_data | input | 8 | Byte driven by the interrupting device |
| iff1 | output | 1 | First enable flip-flop (gates maskable requests) |
| iff2 | output | 1 | Second (shadow) enable flip-flop |
| parity_flag | output | 1 | Parity flag value for the special loads |
| im_mode | output | 2 | Stored interrupt mode |
| ack_wait | output | 1 | Acknowledge wait state in progress |
| resp_valid | output | 1 | Response descriptor valid, one cycle |
| resp_restart | output | 1 | 1: restart to `resp_vector`; 0: execute `resp_opcode` |
| resp_nmi | output | 1 | Response is for the non-maskable interrupt |
| resp_vector | output | 16 | Restart target address |
| resp_opcode | output | 8 | Instruction byte from the device (mode 0) |
| dev_fetch | output | 1 | Instruction bytes come from the device bus |

## Verification
The bench drives the enable flip-flops into the split state (first 0, second 1) through a non-maskable acceptance. Only there do the special-load parity and the return copy show their effect. A design that copied the first flip-flop would give the wrong parity or restore nothing. It places a non-maskable edge and a maskable request at the same boundary, and pulses boundaries during the wait cycles. A design with the wrong priority, or one that re-armed during a response, would emit the wrong vector or an extra response. It counts the wait cycles and samples the device byte exactly at the end of the last wait, so an off-by-one wait count or an early capture shows as a wrong opcode or a misplaced response. Random mode writes also exercise mode 2, which must behave like mode 1.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_RESP = 2'd2,
        SEQ_DEVF = 2'd3
    } seq_state_e;

    localparam int MODE_W = 2;
endpackage

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic op_di,
    input  logic op_ei,
    input  logic op_ld_spec,
    input  logic op_retn,
    input  logic take_nmi,
    input  logic take_int,
    output logic iff1,
    output logic iff2,
    output logic parity_flag
);
    typedef struct packed {
        logic en1;
        logic en2;
        logic par;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_nmi) begin
            st_d.en1 = 1'b0;
        end else if (take_int) begin
            st_d.en1 = 1'b0;
            st_d.en2 = 1'b0;
        end else if (op_di) begin
            st_d.en1 = 1'b0;
            st_d.en2 = 1'b0;
        end else if (op_ei) begin
            st_d.en1 = 1'b1;
            st_d.en2 = 1'b1;
        end else if (op_retn) begin
            st_d.en1 = st_q.en2;
        end
        if (op_ld_spec) begin
            st_d.par = st_q.en2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign iff1        = st_q.en1;
    assign iff2        = st_q.en2;
    assign parity_flag = st_q.par;

    // R4: non-maskable acceptance drops only the first flip-flop
    p_nmi_keeps_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |=> (!iff1 && iff2 == $past(iff2)));

    // R6: maskable acceptance drops both flip-flops
    p_int_clears_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> (!iff1 && !iff2));

    // R3: special load leaves flip-flops alone and mirrors the shadow
    p_ld_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ld_spec && !take_nmi && !take_int && !op_di && !op_ei && !op_retn)
        |=> (parity_flag == $past(iff2) && $stable(iff1) && $stable(iff2)));

    // R4: return copies shadow into the first flip-flop
    p_retn_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_retn && !take_nmi && !take_int && !op_di && !op_ei)
        |=> (iff1 == $past(iff2)));
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic take_nmi,
    output logic nmi_pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_state_t;

    nmi_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d      = st_q;
        rise      = nmi_req && !st_q.prev;
        st_d.prev = nmi_req;
        if (take_nmi) begin
            st_d.pend = 1'b0;
        end
        if (rise) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi_pend = st_q.pend;

    // R5: every rising edge leaves a pending request behind
    p_edge_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |=> nmi_pend);

    // R5: a pending request holds until it is serviced
    p_pend_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !take_nmi) |=> nmi_pend);
endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
    import irq_ctl_pkg::*;
#(
    parameter int          ACK_WAITS = 2,
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] NMI_VEC   = 16'h0066,
    parameter logic [15:0] INT_VEC   = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_nmi,
    input  logic              take_int,
    input  logic              insn_bound,
    input  logic              im_wr,
    input  logic [MODE_W-1:0] im_val,
    input  logic [DATA_W-1:0] ack_data,
    output logic              seq_idle,
    output logic [MODE_W-1:0] im_mode,
    output logic              ack_wait,
    output logic              resp_valid,
    output logic              resp_restart,
    output logic              resp_nmi,
    output logic [ADDR_W-1:0] resp_vector,
    output logic [DATA_W-1:0] resp_opcode,
    output logic              dev_fetch
);
    localparam int CNT_W = (ACK_WAITS > 1) ? $clog2(ACK_WAITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_WAITS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [MODE_W-1:0] mode;
        logic              rst_kind;
        logic              nmi;
        logic [ADDR_W-1:0] vec;
        logic [DATA_W-1:0] opc;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (im_wr) begin
            s_d.mode = im_val;
        end
        unique case (s_q.st)
            SEQ_WAIT: begin
                if (s_q.cnt == CNT_LAST) begin
                    s_d.st  = SEQ_RESP;
                    s_d.opc = s_q.rst_kind ? '0 : ack_data;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SEQ_RESP: begin
                s_d.st = s_q.rst_kind ? SEQ_IDLE : SEQ_DEVF;
            end
            SEQ_DEVF: begin
                if (insn_bound) begin
                    s_d.st = SEQ_IDLE;
                end
            end
            default: ;
        endcase
        if (take_nmi) begin
            s_d.st       = SEQ_RESP;
            s_d.nmi      = 1'b1;
            s_d.rst_kind = 1'b1;
            s_d.vec      = ADDR_W'(NMI_VEC);
            s_d.opc      = '0;
        end else if (take_int) begin
            s_d.st       = SEQ_WAIT;
            s_d.cnt      = '0;
            s_d.nmi      = 1'b0;
            s_d.rst_kind = (s_q.mode != '0);
            s_d.vec      = (s_q.mode != '0) ? ADDR_W'(INT_VEC) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SEQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign seq_idle     = (s_q.st == SEQ_IDLE) || (s_q.st == SEQ_DEVF);
    assign im_mode      = s_q.mode;
    assign ack_wait     = (s_q.st == SEQ_WAIT);
    assign resp_valid   = (s_q.st == SEQ_RESP);
    assign resp_restart = s_q.rst_kind;
    assign resp_nmi     = s_q.nmi;
    assign resp_vector  = s_q.vec;
    assign resp_opcode  = s_q.opc;
    assign dev_fetch    = ((s_q.st == SEQ_RESP) && !s_q.rst_kind) || (s_q.st == SEQ_DEVF);

    // R8: acceptance opens the wait window on the next cycle
    p_wait_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> ack_wait);

    // R8: the wait window always ends in a response
    p_wait_ends_in_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_wait) |-> resp_valid);

    // R12: a response lasts one cycle
    p_resp_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R5: a non-maskable response always restarts at its fixed address
    p_nmi_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_nmi) |-> (resp_restart && resp_vector == ADDR_W'(NMI_VEC)));

    // R11: mode holds unless written
    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !im_wr |=> $stable(im_mode));
endmodule

// File: rtl/cpu_irq_ctl.sv
module cpu_irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int          ACK_WAITS = 2,
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] NMI_VEC   = 16'h0066,
    parameter logic [15:0] INT_VEC   = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_bound,
    input  logic              op_di,
    input  logic              op_ei,
    input  logic              op_ld_spec,
    input  logic              op_retn,
    input  logic              im_wr,
    input  logic [1:0]        im_val,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic [DATA_W-1:0] ack_data,
    output logic              iff1,
    output logic              iff2,
    output logic              parity_flag,
    output logic [1:0]        im_mode,
    output logic              ack_wait,
    output logic              resp_valid,
    output logic              resp_restart,
    output logic              resp_nmi,
    output logic [ADDR_W-1:0] resp_vector,
    output logic [DATA_W-1:0] resp_opcode,
    output logic              dev_fetch
);
    logic nmi_pend;
    logic seq_idle;
    logic take_nmi;
    logic take_int;

    // Acceptance decision: non-maskable first, maskable gated by iff1
    always_comb begin
        take_nmi = insn_bound && seq_idle && nmi_pend;
        take_int = insn_bound && seq_idle && !nmi_pend && irq_req && iff1;
    end

    irq_nmi_latch u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .take_nmi (take_nmi),
        .nmi_pend (nmi_pend)
    );

    irq_enable_ff u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_di       (op_di),
        .op_ei       (op_ei),
        .op_ld_spec  (op_ld_spec),
        .op_retn     (op_retn),
        .take_nmi    (take_nmi),
        .take_int    (take_int),
        .iff1        (iff1),
        .iff2        (iff2),
        .parity_flag (parity_flag)
    );

    irq_resp_seq #(
        .ACK_WAITS (ACK_WAITS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NMI_VEC   (NMI_VEC),
        .INT_VEC   (INT_VEC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_nmi     (take_nmi),
        .take_int     (take_int),
        .insn_bound   (insn_bound),
        .im_wr        (im_wr),
        .im_val       (im_val),
        .ack_data     (ack_data),
        .seq_idle     (seq_idle),
        .im_mode      (im_mode),
        .ack_wait     (ack_wait),
        .resp_valid   (resp_valid),
        .resp_restart (resp_restart),
        .resp_nmi     (resp_nmi),
        .resp_vector  (resp_vector),
        .resp_opcode  (resp_opcode),
        .dev_fetch    (dev_fetch)
    );

    // R7: with a non-maskable edge pending, a boundary never opens a maskable wait
    p_nmi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_bound && seq_idle && nmi_pend) |=> (!ack_wait && resp_valid && resp_nmi));

    // R6: with iff1 low and nothing pending, a boundary never starts a response
    p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_bound && seq_idle && !nmi_pend && !iff1) |=> (!ack_wait && !resp_valid));
endmodule

// File: tb/cpu_irq_ctl_tb.sv
module cpu_irq_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_bound = 1'b0;
    logic        op_di = 1'b0;
    logic        op_ei = 1'b0;
    logic        op_ld_spec = 1'b0;
    logic        op_retn = 1'b0;
    logic        im_wr = 1'b0;
    logic [1:0]  im_val = 2'd0;
    logic        nmi_req = 1'b0;
    logic        irq_req = 1'b0;
    logic [7:0]  ack_data = 8'd0;
    logic        iff1, iff2, parity_flag;
    logic [1:0]  im_mode;
    logic        ack_wait, resp_valid, resp_restart, resp_nmi, dev_fetch;
    logic [15:0] resp_vector;
    logic [7:0]  resp_opcode;

    int n_chk = 0;
    int n_bad = 0;
    logic m1 = 1'b0, m2 = 1'b0, mp = 1'b0;

    always #10 clk = ~clk;

    cpu_irq_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .insn_bound(insn_bound),
        .op_di(op_di), .op_ei(op_ei), .op_ld_spec(op_ld_spec), .op_retn(op_retn),
        .im_wr(im_wr), .im_val(im_val), .nmi_req(nmi_req), .irq_req(irq_req),
        .ack_data(ack_data), .iff1(iff1), .iff2(iff2), .parity_flag(parity_flag),
        .im_mode(im_mode), .ack_wait(ack_wait), .resp_valid(resp_valid),
        .resp_restart(resp_restart), .resp_nmi(resp_nmi), .resp_vector(resp_vector),
        .resp_opcode(resp_opcode), .dev_fetch(dev_fetch)
    );

    function automatic logic [15:0] exp_vec(input logic [1:0] m);
        return (m == 2'd0) ? 16'h0000 : 16'h0038;
    endfunction

    function automatic logic exp_rst(input logic [1:0] m);
        return m != 2'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_en(input string tag);
        check({tag, " iff1"}, {31'd0, iff1}, {31'd0, m1});
        check({tag, " iff2"}, {31'd0, iff2}, {31'd0, m2});
        check({tag, " parity"}, {31'd0, parity_flag}, {31'd0, mp});
    endtask

    task automatic set_mode(input logic [1:0] m);
        im_wr = 1'b1; im_val = m; tick();
        im_wr = 1'b0; im_val = 2'd0;
        check("R11 mode stored", {30'd0, im_mode}, {30'd0, m});
    endtask

    task automatic do_ei();
        op_ei = 1'b1; tick(); op_ei = 1'b0;
        m1 = 1'b1; m2 = 1'b1;
        chk_en("R2 ei");
    endtask

    task automatic do_nmi();
        nmi_req = 1'b1; tick();
        nmi_req = 1'b0; insn_bound = 1'b1; tick();
        insn_bound = 1'b0;
        m1 = 1'b0;
        check("R5 nmi resp_valid", {31'd0, resp_valid}, 32'd1);
        check("R5 nmi vector", {16'd0, resp_vector}, 32'h0066);
        check("R5 nmi restart", {31'd0, resp_restart}, 32'd1);
        check("R5 nmi flag", {31'd0, resp_nmi}, 32'd1);
        check("R5 nmi no wait", {31'd0, ack_wait}, 32'd0);
        chk_en("R4 nmi accept");
        tick();
        check("R5 nmi single", {31'd0, resp_valid}, 32'd0);
    endtask

    task automatic do_int(input logic [1:0] m, input logic [7:0] b);
        irq_req = 1'b1; insn_bound = 1'b1; tick();
        irq_req = 1'b0; insn_bound = 1'b0;
        m1 = 1'b0; m2 = 1'b0;
        check("R8 wait1", {31'd0, ack_wait}, 32'd1);
        check("R8 no early resp", {31'd0, resp_valid}, 32'd0);
        chk_en("R6 int accept");
        ack_data = ~b; tick();
        check("R8 wait2", {31'd0, ack_wait}, 32'd1);
        ack_data = b; tick();
        ack_data = 8'h00;
        check("R8 resp after two waits", {31'd0, resp_valid}, 32'd1);
        check("R8 wait over", {31'd0, ack_wait}, 32'd0);
        check("R9 R10 restart kind", {31'd0, resp_restart}, {31'd0, exp_rst(m)});
        check("R9 not nmi", {31'd0, resp_nmi}, 32'd0);
        if (exp_rst(m)) check("R9 vector", {16'd0, resp_vector}, {16'd0, exp_vec(m)});
        else            check("R10 opcode", {24'd0, resp_opcode}, {24'd0, b});
        check("R10 dev_fetch resp", {31'd0, dev_fetch}, {31'd0, !exp_rst(m)});
        tick();
        check("R8 single resp", {31'd0, resp_valid}, 32'd0);
        check("R10 dev_fetch hold", {31'd0, dev_fetch}, {31'd0, !exp_rst(m)});
        insn_bound = 1'b1; tick(); insn_bound = 1'b0;
        check("R10 dev_fetch ends", {31'd0, dev_fetch}, 32'd0);
        check("R6 no second accept", {31'd0, ack_wait}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 iff1", {31'd0, iff1}, 32'd0);
        check("R1 iff2", {31'd0, iff2}, 32'd0);
        check("R1 parity", {31'd0, parity_flag}, 32'd0);
        check("R1 mode", {30'd0, im_mode}, 32'd0);
        check("R1 idle", {29'd0, resp_valid, ack_wait, dev_fetch}, 32'd0);

        // R6: masked request and non-boundary request ignored
        irq_req = 1'b1; insn_bound = 1'b1; tick(); insn_bound = 1'b0;
        check("R6 masked no wait", {31'd0, ack_wait}, 32'd0);
        do_ei();
        tick();
        check("R6 no boundary no wait", {31'd0, ack_wait}, 32'd0);
        irq_req = 1'b0;

        // R10 mode 0 after reset, device byte
        do_ei();
        do_int(2'd0, 8'hCD);

        // R4/R3 split state: nmi then parity then retn
        do_ei();
        do_nmi();
        op_ld_spec = 1'b1; tick(); op_ld_spec = 1'b0;
        mp = m2;
        chk_en("R3 parity from shadow");
        op_retn = 1'b1; tick(); op_retn = 1'b0;
        m1 = m2;
        chk_en("R4 retn restore");
        op_di = 1'b1; tick(); op_di = 1'b0;
        m1 = 1'b0; m2 = 1'b0;
        chk_en("R2 di");

        // R5: nmi accepted with enables clear
        do_nmi();

        // R7: priority with both pending
        do_ei();
        nmi_req = 1'b1; tick(); nmi_req = 1'b0;
        irq_req = 1'b1; insn_bound = 1'b1; tick();
        irq_req = 1'b0; insn_bound = 1'b0;
        m1 = 1'b0;
        check("R7 nmi wins", {31'd0, resp_nmi}, 32'd1);
        check("R7 resp", {31'd0, resp_valid}, 32'd1);
        check("R7 no wait", {31'd0, ack_wait}, 32'd0);
        chk_en("R7 shadow kept");
        tick();
        check("R7 masked request not answered", {30'd0, resp_valid, ack_wait}, 32'd0);

        // R12: boundaries during a maskable response ignored
        set_mode(2'd1);
        do_ei();
        irq_req = 1'b1; insn_bound = 1'b1; tick();
        irq_req = 1'b0; nmi_req = 1'b1; tick();
        nmi_req = 1'b0; tick();
        check("R12 maskable resp", {30'd0, resp_valid, resp_nmi}, 32'd2);
        tick();
        check("R12 no resp from held boundary", {31'd0, resp_valid}, 32'd0);
        tick();
        check("R12 nmi after response", {30'd0, resp_valid, resp_nmi}, 32'd3);
        insn_bound = 1'b0; tick();
        m1 = 1'b0; m2 = 1'b0;
        chk_en("R12 enables");

        // R9/R10/R11 random maskable trials, including mode 2
        for (int i = 0; i < 40; i++) begin
            logic [1:0] md;
            logic [7:0] bt;
            md = 2'($urandom_range(0, 2));
            bt = 8'($urandom);
            set_mode(md);
            do_ei();
            do_int(md, bt);
        end

        // R2/R3/R4 random enable-strobe sequences
        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0: begin op_di = 1'b1; tick(); op_di = 1'b0; m1 = 1'b0; m2 = 1'b0; chk_en("R2 rnd di"); end
                1: begin op_ei = 1'b1; tick(); op_ei = 1'b0; m1 = 1'b1; m2 = 1'b1; chk_en("R2 rnd ei"); end
                2: begin op_ld_spec = 1'b1; tick(); op_ld_spec = 1'b0; mp = m2; chk_en("R3 rnd ld"); end
                3: begin op_retn = 1'b1; tick(); op_retn = 1'b0; m1 = m2; chk_en("R4 rnd retn"); end
                4: begin tick(); chk_en("R2 rnd idle"); end
                default: do_nmi();
            endcase
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule